// File: doc/BRIEF.md
# Four-Phase Handshake Bus Master

This block lets a local client start single read or write transfers on a shared, unclocked request/acknowledge bus. Address and data use the same set of lines. The master drives those lines through an output-enable, marks the address phase with a separate strobe, and drives a direction line. A slave may take any amount of time to answer. Every edge the master makes waits for the slave's opposite edge, so the transfer needs no common bus clock. The incoming acknowledge is brought into the local clock domain through two flops before the controller acts on it.

The client offers a command with a valid/ready handshake. The master accepts a command only while it is idle. It then places the address on the lines for a programmable settle interval so that slaves can decode it. On a write it next places the data on the lines. On a read it releases the lines for one quiet cycle. After that it raises request. The slave's acknowledge ends the transfer: request falls, and on a read the master captures the data. When the slave lowers acknowledge, the client gets a one-cycle done pulse. If acknowledge fails to rise or fails to fall within a programmable window, the master aborts. It releases the bus and reports an error with the done pulse.

Top module: `hsb_master`

## Requirements
- R1: After reset, `bus_req`, `bus_oe`, `bus_aph`, `rsp_done` and `rsp_error` are low and `cmd_ready` is high.
- R2: A command is taken only on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the master is idle. A `cmd_valid` pulse during a transfer starts no address phase, either during that transfer or after it.
- R3: After a command is accepted, `bus_aph` and `bus_oe` are high with the command address on `bus_ad_o` for exactly SETTLE_CYC cycles. `bus_wr` (1 = write, 0 = read) shows the command direction from the start of the address phase and does not change while `bus_req` is high.
- R4: On both reads and writes, `bus_req` rises exactly SETTLE_CYC+1 cycles after `bus_aph` rises, and `bus_aph` is low in the cycle before `bus_req` rises.
- R5: On a write, `bus_ad_o` carries the write data with `bus_oe` high from the cycle after the address phase until acknowledge is seen. `bus_req` falls on the third rising clock edge after `bus_ack` rises: two synchronizer flops and one state register.
- R6: On a read, `bus_oe` is low from the end of the address phase until the command completes. The cycle in which `bus_oe` falls has `bus_req` low.
- R7: On a read, `rsp_rdata` holds the value of `bus_ad_i` at the edge where the synchronized acknowledge is first seen high. It is valid from the done pulse until the next read.
- R8: `rsp_done` is a one-cycle pulse that rises on the third rising edge after `bus_ack` falls. `cmd_ready` is high in the same cycle.
- R9: If acknowledge is not seen within TIMEOUT_CYC cycles of `bus_req` rising, `bus_req` falls after exactly TIMEOUT_CYC cycles high, and `rsp_done` and `rsp_error` pulse together.
- R10: If acknowledge is not seen low within TIMEOUT_CYC cycles of `bus_req` falling, `rsp_done` and `rsp_error` pulse together TIMEOUT_CYC cycles after `bus_req` falls.
- R11: `rsp_error` stays low on every transfer that completes all four handshake edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Client offers a command |
| cmd_ready | output | 1 | Master is idle and takes a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | W | Transfer address |
| cmd_wdata | input | W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Abort flag, valid with rsp_done |
| rsp_rdata | output | W | Captured read data |
| bus_ad_o | output | W | Value driven onto the shared lines |
| bus_oe | output | 1 | Output enable for the shared lines |
| bus_ad_i | input | W | Value sensed on the shared lines |
| bus_aph | output | 1 | Address-phase strobe |
| bus_wr | output | 1 | Direction line, 1 = write |
| bus_req | output | 1 | Request |
| bus_ack | input | 1 | Acknowledge from slave, asynchronous |

## Verification
The hardest situations to reach are the two abort paths. The second is harder, because it needs a slave that acknowledges correctly and then holds acknowledge high long after request has fallen. The bench slave is behavioural and has a mode register. One mode never answers, and another keeps acknowledge high for longer than the timeout window. The bench then measures, from the pins, how long request stays high and how far done lags the fall of request. A slave-side drive flag is also monitored against the master's output enable on every read, so that any overlap on the shared lines is caught during the turnaround.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_TURN = 3'd2,
    ST_WDAT = 3'd3,
    ST_REQ  = 3'd4,
    ST_REL  = 3'd5
  } hsb_state_t;

  // Output enable for the shared lines in a given state.
  function automatic logic lines_driven(hsb_state_t s, logic wr);
    case (s)
      ST_ADDR:         lines_driven = 1'b1;
      ST_WDAT, ST_REQ: lines_driven = wr;
      default:         lines_driven = 1'b0;
    endcase
  endfunction

  function automatic logic req_level(hsb_state_t s);
    req_level = (s == ST_REQ);
  endfunction

  function automatic logic addr_strobe(hsb_state_t s);
    addr_strobe = (s == ST_ADDR);
  endfunction

  // Counter load value for an interval of n cycles.
  function automatic int unsigned window_load(int unsigned n);
    window_load = (n > 0) ? n - 1 : 0;
  endfunction

endpackage

// File: rtl/hsb_sync2.sv
module hsb_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic meta_q;
  logic stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/hsb_timer.sv
module hsb_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/hsb_fsm.sv
module hsb_fsm
  import hsb_pkg::*;
#(
  parameter int unsigned CW          = 8,
  parameter int unsigned SETTLE_CYC  = 3,
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_fire,
  input  logic          wr_q,
  input  logic          ack_s,
  input  logic          tmr_expired,
  output hsb_state_t    state_q,
  output hsb_state_t    state_d,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          ev_leave_addr,
  output logic          ev_ack_seen,
  output logic          ev_ack_gone,
  output logic          ev_timeout
);
  localparam logic [CW-1:0] SETTLE_LD  = CW'(window_load(SETTLE_CYC));
  localparam logic [CW-1:0] TIMEOUT_LD = CW'(window_load(TIMEOUT_CYC));

  always_comb begin
    state_d       = state_q;
    tmr_load      = 1'b0;
    tmr_val       = '0;
    ev_leave_addr = 1'b0;
    ev_ack_seen   = 1'b0;
    ev_ack_gone   = 1'b0;
    ev_timeout    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_fire) begin
          state_d  = ST_ADDR;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
        end
      end
      ST_ADDR: begin
        if (tmr_expired) begin
          state_d       = wr_q ? ST_WDAT : ST_TURN;
          ev_leave_addr = 1'b1;
        end
      end
      ST_TURN, ST_WDAT: begin
        state_d  = ST_REQ;
        tmr_load = 1'b1;
        tmr_val  = TIMEOUT_LD;
      end
      ST_REQ: begin
        if (ack_s) begin
          state_d     = ST_REL;
          tmr_load    = 1'b1;
          tmr_val     = TIMEOUT_LD;
          ev_ack_seen = 1'b1;
        end else if (tmr_expired) begin
          state_d    = ST_IDLE;
          ev_timeout = 1'b1;
        end
      end
      ST_REL: begin
        if (!ack_s) begin
          state_d     = ST_IDLE;
          ev_ack_gone = 1'b1;
        end else if (tmr_expired) begin
          state_d    = ST_IDLE;
          ev_timeout = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/hsb_master.sv
module hsb_master
  import hsb_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned SETTLE_CYC  = 3,
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic         cmd_write,
  input  logic [W-1:0] cmd_addr,
  input  logic [W-1:0] cmd_wdata,
  output logic         rsp_done,
  output logic         rsp_error,
  output logic [W-1:0] rsp_rdata,
  output logic [W-1:0] bus_ad_o,
  output logic         bus_oe,
  input  logic [W-1:0] bus_ad_i,
  output logic         bus_aph,
  output logic         bus_wr,
  output logic         bus_req,
  input  logic         bus_ack
);
  localparam int unsigned MAX_WIN = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int unsigned CW      = $clog2(MAX_WIN + 1);

  hsb_state_t    state_q;
  hsb_state_t    state_d;
  logic          ack_s;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;

  // Named internal events, visible to the bound checker.
  logic ev_accept;
  logic ev_leave_addr;
  logic ev_ack_seen;
  logic ev_ack_gone;
  logic ev_timeout;

  logic         wr_q;
  logic [W-1:0] wdata_q;
  logic [W-1:0] ad_q;
  logic [W-1:0] rdata_q;
  logic         oe_q;
  logic         req_q;
  logic         aph_q;
  logic         done_q;
  logic         err_q;
  logic         wr_next;

  assign cmd_ready = (state_q == ST_IDLE);
  assign ev_accept = cmd_valid & cmd_ready;
  assign wr_next   = ev_accept ? cmd_write : wr_q;

  hsb_sync2 u_ack_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (bus_ack),
    .sync_o  (ack_s)
  );

  hsb_timer #(.CW(CW)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  hsb_fsm #(
    .CW          (CW),
    .SETTLE_CYC  (SETTLE_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_fire      (ev_accept),
    .wr_q          (wr_q),
    .ack_s         (ack_s),
    .tmr_expired   (tmr_expired),
    .state_q       (state_q),
    .state_d       (state_d),
    .tmr_load      (tmr_load),
    .tmr_val       (tmr_val),
    .ev_leave_addr (ev_leave_addr),
    .ev_ack_seen   (ev_ack_seen),
    .ev_ack_gone   (ev_ack_gone),
    .ev_timeout    (ev_timeout)
  );

  // Command capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (ev_accept) begin
      wr_q    <= cmd_write;
      wdata_q <= cmd_wdata;
    end
  end

  // Bus control outputs come from flops decoded from the next state,
  // so the unclocked bus never sees decode glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      req_q <= 1'b0;
      aph_q <= 1'b0;
    end else begin
      oe_q  <= lines_driven(state_d, wr_next);
      req_q <= req_level(state_d);
      aph_q <= addr_strobe(state_d);
    end
  end

  // Shared-line value: address first, then write data.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_q <= '0;
    end else if (ev_accept) begin
      ad_q <= cmd_addr;
    end else if (ev_leave_addr && wr_q) begin
      ad_q <= wdata_q;
    end
  end

  // Read capture at the acknowledge edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (ev_ack_seen && !wr_q) begin
      rdata_q <= bus_ad_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= ev_ack_gone | ev_timeout;
      err_q  <= ev_timeout;
    end
  end

  assign bus_ad_o  = ad_q;
  assign bus_oe    = oe_q;
  assign bus_req   = req_q;
  assign bus_aph   = aph_q;
  assign bus_wr    = wr_q;
  assign rsp_done  = done_q;
  assign rsp_error = err_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/hsb_master_chk.sv
module hsb_master_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_ready,
  input logic         rsp_done,
  input logic         rsp_error,
  input logic         bus_req,
  input logic         bus_oe,
  input logic         bus_aph,
  input logic         bus_wr,
  input logic [W-1:0] bus_ad_o,
  input logic         ev_ack_seen,
  input logic         ev_timeout
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!bus_req && !bus_oe && !bus_aph)); // R2

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_aph && $past(bus_aph)) |-> ($stable(bus_ad_o) && bus_oe)); // R3

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> $stable(bus_wr)); // R3

  AST_REQ_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (!bus_aph && !$past(bus_aph))); // R4

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_seen |=> !bus_req); // R5

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr) |-> !bus_oe); // R6

  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_oe) && !bus_wr) |-> !bus_req); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R8

  AST_ABORT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> (rsp_done && !bus_req && !bus_oe)); // R9

  AST_TIMEOUT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (rsp_error && rsp_done)); // R10

endmodule

bind hsb_master hsb_master_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_ready   (cmd_ready),
  .rsp_done    (rsp_done),
  .rsp_error   (rsp_error),
  .bus_req     (bus_req),
  .bus_oe      (bus_oe),
  .bus_aph     (bus_aph),
  .bus_wr      (bus_wr),
  .bus_ad_o    (bus_ad_o),
  .ev_ack_seen (ev_ack_seen),
  .ev_timeout  (ev_timeout)
);

// File: tb/hsb_master_tb.sv
module hsb_master_tb_top;
  localparam int unsigned W       = 16;
  localparam int unsigned SETTLE  = 3;
  localparam int unsigned TIMEOUT = 40;

  typedef struct packed {
    logic         wr;
    logic [15:0]  addr;
    logic [15:0]  data;
    logic [3:0]   rdly;
    logic [3:0]   fdly;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h1000, 16'hA5A5, 4'd0, 4'd0},
    '{1'b0, 16'h1000, 16'h5A5A, 4'd0, 4'd0},
    '{1'b1, 16'hFFFF, 16'h0000, 4'd3, 4'd1},
    '{1'b0, 16'h0001, 16'hFFFF, 4'd5, 4'd4},
    '{1'b0, 16'h7F00, 16'h1234, 4'd1, 4'd2},
    '{1'b1, 16'h00FF, 16'hCAFE, 4'd7, 4'd0},
    '{1'b0, 16'hAAAA, 16'h8001, 4'd2, 4'd7},
    '{1'b1, 16'h5555, 16'h0F0F, 4'd1, 4'd3}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic         cmd_write = 1'b0;
  logic [W-1:0] cmd_addr = '0;
  logic [W-1:0] cmd_wdata = '0;
  logic         rsp_done;
  logic         rsp_error;
  logic [W-1:0] rsp_rdata;
  logic [W-1:0] bus_ad_o;
  logic         bus_oe;
  logic [W-1:0] bus_ad_i;
  logic         bus_aph;
  logic         bus_wr;
  logic         bus_req;
  logic         bus_ack = 1'b0;

  logic         slave_de = 1'b0;
  logic [W-1:0] slave_val = '0;

  assign bus_ad_i = slave_de ? slave_val : (bus_oe ? bus_ad_o : '0);

  always #2 clk = ~clk;

  hsb_master #(.W(W), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TIMEOUT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .bus_ad_o(bus_ad_o), .bus_oe(bus_oe), .bus_ad_i(bus_ad_i),
    .bus_aph(bus_aph), .bus_wr(bus_wr), .bus_req(bus_req), .bus_ack(bus_ack)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural slave. Mode 0 normal, 1 never acknowledges, 2 holds acknowledge.
  int           s_mode = 0;
  int           s_rdly = 0;
  int           s_fdly = 0;
  logic [W-1:0] s_rdata = '0;
  logic [W-1:0] s_addr = '0;
  logic [W-1:0] s_wdata = '0;
  int           s_lat_rise = 0;
  int           s_lat_done = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (bus_aph) s_addr = bus_ad_o;
      if (bus_req) begin
        if (s_mode == 1) begin
          while (bus_req) @(negedge clk);
        end else begin
          repeat (s_rdly) @(negedge clk);
          if (!bus_wr) begin
            slave_val = s_rdata;
            slave_de  = 1'b1;
            @(negedge clk);
          end else begin
            s_wdata = bus_ad_o;
          end
          bus_ack = 1'b1;
          s_lat_rise = 0;
          while (bus_req && s_lat_rise < 100) begin
            @(negedge clk);
            s_lat_rise++;
          end
          slave_de = 1'b0;
          if (s_mode == 2) repeat (TIMEOUT + 10) @(negedge clk);
          else             repeat (s_fdly) @(negedge clk);
          bus_ack = 1'b0;
          if (s_mode == 0) begin
            s_lat_done = 0;
            do begin
              @(negedge clk);
              s_lat_done++;
            end while (!rsp_done && s_lat_done < 20);
          end
        end
      end
    end
  end

  // Pin-level monitor.
  logic prev_aph = 1'b0, prev_req = 1'b0, prev_done = 1'b0;
  int   aph_len = 0, gap = 0, last_gap = 0, req_cnt = 0, last_req_len = 0;
  int   f2d = 0, last_f2d = 0;
  bit   gap_run = 0, f2d_run = 0, overlap = 0, dbl_done = 0;

  always @(negedge clk) begin
    if (bus_aph && !prev_aph) begin
      aph_len = 0; gap = 0; gap_run = 1;
    end else if (gap_run) begin
      gap++;
    end
    if (bus_aph) aph_len++;
    if (gap_run && bus_req && !prev_req) begin
      last_gap = gap; gap_run = 0;
    end
    if (bus_req && !prev_req) req_cnt = 1;
    else if (bus_req) req_cnt++;
    if (!bus_req && prev_req) begin
      last_req_len = req_cnt; f2d = 0; f2d_run = 1;
    end else if (f2d_run) begin
      f2d++;
    end
    if (f2d_run && rsp_done) begin
      last_f2d = f2d; f2d_run = 0;
    end
    if ((!bus_wr && bus_req && bus_oe) || (slave_de && bus_oe)) overlap = 1;
    if (rsp_done && prev_done) dbl_done = 1;
    prev_aph = bus_aph; prev_req = bus_req; prev_done = rsp_done;
  end

  logic         got_err;
  logic [W-1:0] got_rdata;

  task automatic issue(input logic wr, input logic [W-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!rsp_done && n < 500) begin
      @(negedge clk);
      n++;
    end
    got_err   = rsp_error;
    got_rdata = rsp_rdata;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!bus_req && !bus_oe && !bus_aph, "R1 bus outputs idle", {bus_req, bus_oe, bus_aph}, 0);
    chk(!rsp_done && !rsp_error, "R1 response idle", {rsp_done, rsp_error}, 0);
    chk(cmd_ready, "R1 ready", cmd_ready, 1);

    for (int i = 0; i < NV; i++) begin
      s_mode = 0; s_rdly = VECS[i].rdly; s_fdly = VECS[i].fdly; s_rdata = VECS[i].data;
      overlap = 0; dbl_done = 0;
      issue(VECS[i].wr, VECS[i].addr, VECS[i].data);
      wait_done();
      chk(s_addr == VECS[i].addr, "R3 address seen by slave", s_addr, VECS[i].addr);
      chk(aph_len == SETTLE, "R3 address phase length", aph_len, SETTLE);
      chk(last_gap == SETTLE + 1, "R4 request delay", last_gap, SETTLE + 1);
      chk(s_lat_rise == 3, "R5 request fall after ack", s_lat_rise, 3);
      chk(s_lat_done == 3, "R8 done after ack release", s_lat_done, 3);
      chk(!dbl_done, "R8 single pulse", dbl_done, 0);
      chk(!got_err, "R11 no error", got_err, 0);
      if (VECS[i].wr) begin
        chk(s_wdata == VECS[i].data, "R5 write data", s_wdata, VECS[i].data);
      end else begin
        chk(got_rdata == VECS[i].data, "R7 read data", got_rdata, VECS[i].data);
        chk(!overlap, "R6 no drive overlap on read", overlap, 0);
      end
      repeat (2) @(negedge clk);
    end

    // R2: command offered while busy is ignored
    s_mode = 0; s_rdly = 4; s_fdly = 2; s_rdata = 16'h3C3C;
    issue(1'b0, 16'h2468, 16'h0);
    while (!bus_req) @(negedge clk);
    chk(!cmd_ready, "R2 not ready while busy", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'hBEEF; cmd_wdata = 16'h1111;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    chk(got_rdata == 16'h3C3C, "R7 read data during busy test", got_rdata, 16'h3C3C);
    begin
      int aph_seen;
      aph_seen = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (bus_aph) aph_seen++;
      end
      chk(aph_seen == 0, "R2 busy command not started", aph_seen, 0);
      chk(s_addr == 16'h2468, "R2 slave address unchanged", s_addr, 16'h2468);
    end

    // R9: acknowledge never rises
    s_mode = 1;
    issue(1'b0, 16'h0BAD, 16'h0);
    wait_done();
    chk(got_err, "R9 error on missing ack", got_err, 1);
    chk(last_req_len == TIMEOUT, "R9 request high time", last_req_len, TIMEOUT);
    chk(!bus_req && !bus_oe, "R9 bus released", {bus_req, bus_oe}, 0);

    // R10: acknowledge stuck high
    repeat (4) @(negedge clk);
    s_mode = 2; s_rdly = 1;
    issue(1'b1, 16'h0DEA, 16'h7777);
    wait_done();
    chk(got_err, "R10 error on stuck ack", got_err, 1);
    chk(last_f2d == TIMEOUT, "R10 done delay after request fall", last_f2d, TIMEOUT);
    chk(cmd_ready, "R10 ready after abort", cmd_ready, 1);
    while (bus_ack) @(negedge clk);
    repeat (4) @(negedge clk);

    // Recovery read after the aborts
    s_mode = 0; s_rdly = 2; s_fdly = 1; s_rdata = 16'h6B6B;
    issue(1'b0, 16'h4321, 16'h0);
    wait_done();
    chk(got_rdata == 16'h6B6B, "R7 read after abort", got_rdata, 16'h6B6B);
    chk(!got_err, "R11 no error after recovery", got_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule